// File: doc/BRIEF.md
# Iterative AES-128 Encrypt/Decrypt Core

This block turns one 128-bit data block into ciphertext or back into plaintext under a 128-bit key, following the ten-round AES-128 algorithm. A single round unit does the work for both directions. Multiplexers choose either the forward path (ShiftRows, SubBytes, MixColumns) or the inverse path (InvShiftRows, InvSubBytes, InvMixColumns). One round finishes per clock, after an initial key addition that is made when the block is accepted. The S-box has no lookup table. Each byte is mapped into the composite field GF((2^4)^2), inverted there and mapped back. The affine step is applied after the inversion when encrypting, and its inverse is applied before the inversion when decrypting.

Round keys are never stored as a table. Each one is derived combinationally from the previous round key in the cycle that uses it. When a key is loaded, the core makes one forward pass over the key schedule and keeps the final round key. Decryption can then walk the schedule backwards from that key, with no extra work at the start of a block.

A host loads a key with a one-cycle strobe and waits for busy to drop. It then presents a block with a start strobe and the direction bit, and collects the result when done pulses.

Top module: `aes_shared_core`

## Requirements
- R1: A keyLoad pulse sampled while busy is low captures keyIn. busy is then high for exactly 10 cycles, starting in the cycle after the sampling edge, while the key schedule is expanded forward.
- R2: With mode = 0 (encrypt), the result equals AES-128 encryption of dataIn under the loaded key. Bytes are taken most significant first: bits 127:120 are the first byte of the block and of the key.
- R3: With mode = 1 (decrypt), the result equals AES-128 decryption of dataIn under the loaded key. This holds even when no encryption has run since the key was loaded.
- R4: When a start pulse is accepted, busy rises in the next cycle. done goes high in the cycle after the 11th rising edge, counting the edge that samples start as the first of the 11.
- R5: done is high for exactly one cycle, and in that cycle dataOut holds the result. While busy is low and no block is accepted, dataOut keeps its value. After reset, done, busy and dataOut are all 0.
- R6: A start pulse, with its mode and dataIn, has no effect while busy is high, whether the core is expanding a key or processing a block. A block already in progress still returns its own result, with the normal latency.
- R7: When keyLoad and start are both high in an idle cycle, the key load is taken and the start is dropped. A keyLoad pulse while busy is high is ignored, and the key already in use is kept.
- R8: A start pulse in the same cycle as done is accepted. The next block then completes with the R4 latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| keyLoad | input | 1 | Strobe that captures keyIn and begins expanding the key schedule |
| keyIn | input | 128 | Cipher key, first byte in bits 127:120 |
| start | input | 1 | Strobe that accepts dataIn as a new block |
| mode | input | 1 | Direction sampled with start: 0 = encrypt, 1 = decrypt |
| dataIn | input | 128 | Input block |
| dataOut | output | 128 | Result register, valid while done is high and held afterwards |
| done | output | 1 | One-cycle pulse when dataOut holds a new result |
| busy | output | 1 | High while a key is being expanded or a block is in progress |

## Verification
Two events can share a cycle here: a key load and a block start requested together while the core is idle, and a finishing block whose done pulse meets a new start. The bench raises keyLoad and start in the same idle cycle. It then checks that busy stays high for only the 10-cycle expansion, that no done follows, and that the next block is ciphered under the new key. It also raises start in the very cycle done is seen. It checks that the old result is on dataOut in that cycle and that the second block finishes after the full 11 edges with the correct value.

// File: rtl/aes_core_pkg.sv
package aes_core_pkg;
  localparam int BLK_W = 128;
  localparam int NB = BLK_W / 8;
  localparam int NCOL = NB / 4;
  localparam int ROUNDS = 10;
  localparam int CNT_W = $clog2(ROUNDS + 2);
  localparam logic [3:0] SUB_LAMBDA = 4'hC;  // y^2 = y + lambda over GF(16), x^4+x+1

  typedef enum logic [1:0] {PH_IDLE, PH_EXPAND, PH_CIPHER} phase_t;

  typedef struct packed {
    logic             captureKey;
    logic             beginBlock;
    logic             expandStep;
    logic             cipherStep;
    logic             lastStep;
    logic             decrypt;
    logic [CNT_W-1:0] rnd;
  } ctlStrobes_t;

  function automatic logic [3:0] gf16Mul(logic [3:0] a, logic [3:0] b);
    logic [3:0] acc, sh;
    acc = '0; sh = a;
    for (int i = 0; i < 4; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[2:0], 1'b0} ^ (sh[3] ? 4'b0011 : 4'b0000);
    end
    return acc;
  endfunction

  function automatic logic [3:0] gf16Inv(logic [3:0] a);
    logic [3:0] a2, a4, a8;
    a2 = gf16Mul(a, a); a4 = gf16Mul(a2, a2); a8 = gf16Mul(a4, a4);
    return gf16Mul(gf16Mul(a8, a4), a2);
  endfunction

  // composite element: {hi, lo} = hi*y + lo
  function automatic logic [7:0] cfMul(logic [7:0] a, logic [7:0] b);
    logic [3:0] hh;
    hh = gf16Mul(a[7:4], b[7:4]);
    return {hh ^ gf16Mul(a[7:4], b[3:0]) ^ gf16Mul(a[3:0], b[7:4]),
            gf16Mul(hh, SUB_LAMBDA) ^ gf16Mul(a[3:0], b[3:0])};
  endfunction

  function automatic logic [7:0] cfInv(logic [7:0] a);
    logic [3:0] h, l, d, di;
    h = a[7:4]; l = a[3:0];
    d = gf16Mul(gf16Mul(h, h), SUB_LAMBDA) ^ gf16Mul(h, l) ^ gf16Mul(l, l);
    di = gf16Inv(d);
    return {gf16Mul(h, di), gf16Mul(h ^ l, di)};
  endfunction

  function automatic logic [7:0] applyCols(logic [7:0][7:0] cols, logic [7:0] v);
    logic [7:0] acc;
    acc = '0;
    for (int i = 0; i < 8; i++) if (v[i]) acc = acc ^ cols[i];
    return acc;
  endfunction

  // columns of the isomorphism: bit i of a byte maps to root^i, root solving x^8+x^4+x^3+x+1
  function automatic logic [7:0][7:0] buildToComp();
    logic [7:0][7:0] cols;
    logic [7:0] r, r2, r4, root;
    logic found;
    root = 8'h02; found = 1'b0;
    for (int i = 2; i < 256; i++) begin
      r = 8'(i);
      r2 = cfMul(r, r); r4 = cfMul(r2, r2);
      if (!found && ((cfMul(r4, r4) ^ r4 ^ cfMul(r2, r) ^ r ^ 8'h01) == 8'h00)) begin
        root = r; found = 1'b1;
      end
    end
    cols[0] = 8'h01;
    for (int i = 1; i < 8; i++) cols[i] = cfMul(cols[i-1], root);
    return cols;
  endfunction

  localparam logic [7:0][7:0] TO_COMP = buildToComp();

  function automatic logic [7:0][7:0] buildFromComp();
    logic [7:0][7:0] cols;
    logic [7:0] m;
    cols = '0;
    for (int i = 0; i < 256; i++) begin
      m = applyCols(TO_COMP, 8'(i));
      for (int j = 0; j < 8; j++) if (m == (8'h01 << j)) cols[j] = 8'(i);
    end
    return cols;
  endfunction

  localparam logic [7:0][7:0] FROM_COMP = buildFromComp();

  function automatic logic [7:0] xtime(logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] rotl8(logic [7:0] b, int k);
    logic [15:0] d;
    d = {b, b};
    return d[15-k -: 8];
  endfunction

  function automatic logic [7:0] fwdAffine(logic [7:0] b);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] invAffine(logic [7:0] b);
    return rotl8(b, 1) ^ rotl8(b, 3) ^ rotl8(b, 6) ^ 8'h05;
  endfunction

  function automatic logic [7:0] rconOf(logic [CNT_W-1:0] n);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 1; i < ROUNDS; i++) if (i < int'(n)) r = xtime(r);
    return r;
  endfunction

  function automatic logic [BLK_W-1:0] shiftRows(logic [BLK_W-1:0] s, logic inv);
    logic [BLK_W-1:0] o;
    int src;
    for (int c = 0; c < NCOL; c++)
      for (int r = 0; r < 4; r++) begin
        src = inv ? ((c - r + NCOL) % NCOL) : ((c + r) % NCOL);
        o[8*(NB-1-(4*c+r)) +: 8] = s[8*(NB-1-(4*src+r)) +: 8];
      end
    return o;
  endfunction

  function automatic logic [31:0] mixCol(logic [31:0] col, logic inv);
    logic [3:0][7:0] a, x2, x4, x8, o;
    for (int k = 0; k < 4; k++) begin
      a[k] = col[31-8*k -: 8];
      x2[k] = xtime(a[k]); x4[k] = xtime(x2[k]); x8[k] = xtime(x4[k]);
    end
    for (int k = 0; k < 4; k++) begin
      if (inv)
        o[k] = (x8[k] ^ x4[k] ^ x2[k]) ^ (x8[(k+1)%4] ^ x2[(k+1)%4] ^ a[(k+1)%4]) ^
               (x8[(k+2)%4] ^ x4[(k+2)%4] ^ a[(k+2)%4]) ^ (x8[(k+3)%4] ^ a[(k+3)%4]);
      else
        o[k] = x2[k] ^ x2[(k+1)%4] ^ a[(k+1)%4] ^ a[(k+2)%4] ^ a[(k+3)%4];
    end
    return {o[0], o[1], o[2], o[3]};
  endfunction

  function automatic logic [BLK_W-1:0] mixState(logic [BLK_W-1:0] s, logic inv);
    logic [BLK_W-1:0] o;
    for (int c = 0; c < NCOL; c++) o[BLK_W-1-32*c -: 32] = mixCol(s[BLK_W-1-32*c -: 32], inv);
    return o;
  endfunction
endpackage

// File: rtl/aes_core_sbox.sv
module aes_core_sbox
  import aes_core_pkg::*;
(
  input  logic       inverse,
  input  logic [7:0] byteIn,
  output logic [7:0] byteOut
);
  logic [7:0] preAff, fieldInv;

  always_comb begin
    preAff   = inverse ? invAffine(byteIn) : byteIn;
    fieldInv = applyCols(FROM_COMP, cfInv(applyCols(TO_COMP, preAff)));
    byteOut  = inverse ? fieldInv : fwdAffine(fieldInv);
  end
endmodule

// File: rtl/aes_core_ctrl.sv
module aes_core_ctrl
  import aes_core_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        keyLoad,
  input  logic        start,
  input  logic        mode,
  output ctlStrobes_t ctl,
  output logic        busy,
  output logic        done
);
  phase_t           phase;
  logic [CNT_W-1:0] rnd;
  logic             modeReg, doneReg;
  logic             idle, atLast;

  assign idle   = (phase == PH_IDLE);
  assign atLast = (rnd == CNT_W'(ROUNDS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      rnd     <= '0;
      modeReg <= 1'b0;
      doneReg <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (keyLoad) begin
            phase <= PH_EXPAND;
            rnd   <= CNT_W'(1);
          end else if (start) begin
            phase   <= PH_CIPHER;
            rnd     <= CNT_W'(1);
            modeReg <= mode;
          end
        end
        PH_EXPAND: begin
          if (atLast) phase <= PH_IDLE;
          else rnd <= rnd + 1'b1;
        end
        PH_CIPHER: begin
          if (atLast) begin
            phase   <= PH_IDLE;
            doneReg <= 1'b1;
          end else rnd <= rnd + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.captureKey = idle & keyLoad;
    ctl.beginBlock = idle & start & ~keyLoad;
    ctl.expandStep = (phase == PH_EXPAND);
    ctl.cipherStep = (phase == PH_CIPHER);
    ctl.lastStep   = atLast;
    ctl.decrypt    = (phase == PH_CIPHER) ? modeReg : mode;
    ctl.rnd        = rnd;
  end

  assign busy = ~idle;
  assign done = doneReg;
endmodule

// File: rtl/aes_core_dpath.sv
module aes_core_dpath
  import aes_core_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      ctl,
  input  logic [BLK_W-1:0] keyIn,
  input  logic [BLK_W-1:0] dataIn,
  output logic [BLK_W-1:0] dataOut
);
  localparam logic [CNT_W-1:0] RND_TOP = CNT_W'(ROUNDS + 1);

  logic [BLK_W-1:0] key0Reg, lastKeyReg, workKey, stateReg;
  logic [BLK_W-1:0] stepKey, startKey, shifted, subState, decAdd, roundOut;
  logic [31:0]      w0, w1, w2, w3, subIn, rotWord, subWord, keyMix;
  logic [31:0]      n0, n1, n2;
  logic             backStep;

  // key schedule step, forward or backward
  assign backStep = ctl.cipherStep & ctl.decrypt;
  assign {w0, w1, w2, w3} = workKey;
  assign subIn   = backStep ? (w3 ^ w2) : w3;
  assign rotWord = {subIn[23:0], subIn[31:24]};

  for (genvar i = 0; i < 4; i++) begin : g_keySbox
    aes_core_sbox u_kbox (.inverse(1'b0), .byteIn(rotWord[31-8*i -: 8]),
                          .byteOut(subWord[31-8*i -: 8]));
  end

  always_comb begin
    keyMix = subWord ^ {rconOf(backStep ? (RND_TOP - ctl.rnd) : ctl.rnd), 24'h0};
    n0 = w0 ^ keyMix;
    n1 = n0 ^ w1;
    n2 = n1 ^ w2;
    stepKey = backStep ? {w0 ^ keyMix, w1 ^ w0, w2 ^ w1, w3 ^ w2} : {n0, n1, n2, n2 ^ w3};
  end

  // shared round unit
  assign shifted = shiftRows(stateReg, ctl.decrypt);

  for (genvar i = 0; i < NB; i++) begin : g_dataSbox
    aes_core_sbox u_dbox (.inverse(ctl.decrypt), .byteIn(shifted[8*i +: 8]),
                          .byteOut(subState[8*i +: 8]));
  end

  always_comb begin
    decAdd = subState ^ stepKey;
    if (ctl.decrypt) roundOut = ctl.lastStep ? decAdd : mixState(decAdd, 1'b1);
    else roundOut = (ctl.lastStep ? subState : mixState(subState, 1'b0)) ^ stepKey;
    startKey = ctl.decrypt ? lastKeyReg : key0Reg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      key0Reg    <= '0;
      lastKeyReg <= '0;
      workKey    <= '0;
      stateReg   <= '0;
    end else begin
      if (ctl.captureKey) begin
        key0Reg <= keyIn;
        workKey <= keyIn;
      end else if (ctl.beginBlock) begin
        workKey  <= startKey;
        stateReg <= dataIn ^ startKey;
      end else if (ctl.expandStep) begin
        workKey <= stepKey;
        if (ctl.lastStep) lastKeyReg <= stepKey;
      end else if (ctl.cipherStep) begin
        workKey  <= stepKey;
        stateReg <= roundOut;
      end
    end
  end

  assign dataOut = stateReg;
endmodule

// File: rtl/aes_shared_core.sv
module aes_shared_core
  import aes_core_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             keyLoad,
  input  logic [BLK_W-1:0] keyIn,
  input  logic             start,
  input  logic             mode,
  input  logic [BLK_W-1:0] dataIn,
  output logic [BLK_W-1:0] dataOut,
  output logic             done,
  output logic             busy
);
  ctlStrobes_t ctl;

  aes_core_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .keyLoad(keyLoad), .start(start), .mode(mode),
    .ctl(ctl), .busy(busy), .done(done)
  );

  aes_core_dpath u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .keyIn(keyIn), .dataIn(dataIn), .dataOut(dataOut)
  );
endmodule

// File: rtl/aes_core_chk.sv
module aes_core_chk (
  input logic         clk,
  input logic         rstN,
  input logic         keyLoad,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [127:0] dataOut
);
  logic [3:0] blkCnt, expCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blkCnt <= '0;
      expCnt <= '0;
    end else begin
      if (start && !busy && !keyLoad) blkCnt <= 4'd1;
      else if (blkCnt != 4'd0 && blkCnt < 4'd11) blkCnt <= blkCnt + 4'd1;
      else blkCnt <= '0;
      if (keyLoad && !busy) expCnt <= 4'd1;
      else if (expCnt != 4'd0 && expCnt < 4'd10) expCnt <= expCnt + 4'd1;
      else expCnt <= '0;
    end
  end

  // R1: expansion keeps busy high for ten cycles, then releases it
  p_expand_len_r1: assert property (@(posedge clk) disable iff (!rstN)
    (expCnt != 4'd0) |-> (busy && !done));
  p_expand_end_r1: assert property (@(posedge clk) disable iff (!rstN)
    (expCnt == 4'd10) |=> !busy);
  // R4: accepted start raises busy; done lands on the eleventh edge
  p_busy_accept_r4: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
  p_latency_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (blkCnt == 4'd11));
  p_latency_hit_r4: assert property (@(posedge clk) disable iff (!rstN)
    (blkCnt == 4'd11) |-> done);
  // R5: single-cycle done, idle output holds
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  p_hold_out_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(dataOut));
endmodule

bind aes_shared_core aes_core_chk u_chk (
  .clk(clk), .rstN(rstN), .keyLoad(keyLoad), .start(start),
  .busy(busy), .done(done), .dataOut(dataOut)
);

// File: tb/aes_shared_core_tb.sv
module aes_shared_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0, rstN = 1'b0;
  logic keyLoad = 1'b0, start = 1'b0, mode = 1'b0;
  logic [127:0] keyIn = '0, dataIn = '0;
  logic [127:0] dataOut;
  logic done, busy;

  int compared = 0, mismatched = 0, cycles = 0;
  bit finished = 1'b0;
  logic [7:0] sbT [256];
  logic [7:0] isbT [256];

  aes_shared_core u_dut (
    .clk(clk), .rstN(rstN), .keyLoad(keyLoad), .keyIn(keyIn), .start(start),
    .mode(mode), .dataIn(dataIn), .dataOut(dataOut), .done(done), .busy(busy)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1'b1;
      compared++; mismatched++;
      $display("FAIL watchdog R4: actual=hung expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // ---------------- reference model ----------------
  function automatic logic [7:0] gm(logic [7:0] a, logic [7:0] b);
    logic [7:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= a;
      a = a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
    end
    return p;
  endfunction

  function automatic logic [127:0] subB(logic [127:0] s, bit inv);
    for (int i = 0; i < 16; i++) s[8*i +: 8] = inv ? isbT[s[8*i +: 8]] : sbT[s[8*i +: 8]];
    return s;
  endfunction

  function automatic logic [127:0] shR(logic [127:0] s, bit inv);
    logic [127:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        if (inv) o[127-8*(4*((c+r)%4)+r) -: 8] = s[127-8*(4*c+r) -: 8];
        else     o[127-8*(4*c+r) -: 8] = s[127-8*(4*((c+r)%4)+r) -: 8];
    return o;
  endfunction

  function automatic logic [127:0] mixB(logic [127:0] s, bit inv);
    logic [127:0] o;
    logic [7:0] m [4];
    if (inv) m = '{8'h0e, 8'h0b, 8'h0d, 8'h09}; else m = '{8'h02, 8'h03, 8'h01, 8'h01};
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        logic [7:0] acc;
        acc = '0;
        for (int k = 0; k < 4; k++) acc ^= gm(m[(k - r + 4) % 4], s[127-8*(4*c+k) -: 8]);
        o[127-8*(4*c+r) -: 8] = acc;
      end
    return o;
  endfunction

  function automatic logic [127:0] model(logic [127:0] key, logic [127:0] blk, bit dec);
    logic [127:0] rk [0:10];
    logic [127:0] s;
    logic [31:0] t, n0, n1, n2;
    logic [7:0] rc;
    rk[0] = key; rc = 8'h01;
    for (int r = 1; r <= 10; r++) begin
      t = rk[r-1][31:0];
      t = {t[23:0], t[31:24]};
      t = {sbT[t[31:24]], sbT[t[23:16]], sbT[t[15:8]], sbT[t[7:0]]} ^ {rc, 24'h0};
      n0 = rk[r-1][127:96] ^ t; n1 = rk[r-1][95:64] ^ n0; n2 = rk[r-1][63:32] ^ n1;
      rk[r] = {n0, n1, n2, rk[r-1][31:0] ^ n2};
      rc = gm(rc, 8'h02);
    end
    if (!dec) begin
      s = blk ^ rk[0];
      for (int r = 1; r <= 10; r++) begin
        s = shR(subB(s, 1'b0), 1'b0);
        if (r < 10) s = mixB(s, 1'b0);
        s ^= rk[r];
      end
    end else begin
      s = blk ^ rk[10];
      for (int r = 9; r >= 0; r--) begin
        s = subB(shR(s, 1'b1), 1'b1) ^ rk[r];
        if (r > 0) s = mixB(s, 1'b1);
      end
    end
    return s;
  endfunction

  // ---------------- helpers ----------------
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic checkVal(input string tag, input logic [127:0] act, input logic [127:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic loadKey(input logic [127:0] k, output int busyLen);
    keyLoad = 1'b1; keyIn = k; tick(); keyLoad = 1'b0;
    busyLen = 0;
    while (busy && busyLen < 40) begin busyLen++; tick(); end
  endtask

  task automatic waitDone(output logic [127:0] res, output int lat);
    lat = 1;
    while (!done && lat < 40) begin tick(); lat++; end
    res = dataOut;
  endtask

  task automatic runBlock(input logic m, input logic [127:0] d,
                          output logic [127:0] res, output int lat);
    start = 1'b1; mode = m; dataIn = d; tick(); start = 1'b0;
    waitDone(res, lat);
  endtask

  localparam logic [127:0] KAT_KEY = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] KAT_PT  = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] KAT_CT  = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;

  initial begin
    logic [127:0] res, res2, curKey, pt, ct, k2, k3;
    int lat, n, seen;

    void'($urandom(32'd20240611));
    for (int a = 0; a < 256; a++) begin
      logic [7:0] inv, s;
      inv = '0;
      for (int b = 1; b < 256; b++) if (gm(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
      s = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^ {inv[4:0], inv[7:5]} ^
          {inv[3:0], inv[7:4]} ^ 8'h63;
      sbT[a] = s; isbT[s] = 8'(a);
    end

    repeat (3) tick();
    rstN = 1'b1; tick();
    checkVal("R5 reset done", {127'd0, done}, 128'd0);
    checkVal("R5 reset busy", {127'd0, busy}, 128'd0);
    checkVal("R5 reset dataOut", dataOut, 128'd0);

    // R1: key load and expansion length
    loadKey(KAT_KEY, n); curKey = KAT_KEY;
    checkVal("R1 expansion busy cycles", 128'(n), 128'd10);

    // R3: decrypt straight after key load
    runBlock(1'b1, KAT_CT, res, lat);
    checkVal("R3 known-answer decrypt", res, KAT_PT);
    // R2 / R4: known-answer encrypt and latency
    runBlock(1'b0, KAT_PT, res, lat);
    checkVal("R2 known-answer encrypt", res, KAT_CT);
    checkVal("R4 latency edges", 128'(lat), 128'd11);
    // R5: done pulse width and hold
    tick();
    checkVal("R5 done one cycle", {127'd0, done}, 128'd0);
    repeat (3) tick();
    checkVal("R5 output held", dataOut, KAT_CT);

    // R6: start while a block is running
    pt = {$urandom(), $urandom(), $urandom(), $urandom()};
    start = 1'b1; mode = 1'b0; dataIn = pt; tick(); start = 1'b0;
    tick(); tick();
    start = 1'b1; mode = 1'b1; dataIn = ~pt; tick(); start = 1'b0;
    waitDone(res, lat);
    lat = lat + 3;
    checkVal("R6 busy start ignored result", res, model(curKey, pt, 1'b0));
    checkVal("R6 busy start latency kept", 128'(lat), 128'd11);
    seen = 0;
    for (int i = 0; i < 14; i++) begin tick(); if (done) seen++; end
    checkVal("R6 no extra done after block", 128'(seen), 128'd0);

    // R6: start during key expansion
    k2 = {$urandom(), $urandom(), $urandom(), $urandom()};
    keyLoad = 1'b1; keyIn = k2; tick(); keyLoad = 1'b0;
    start = 1'b1; mode = 1'b0; dataIn = pt; tick(); start = 1'b0;
    seen = 0;
    for (int i = 0; i < 24; i++) begin tick(); if (done) seen++; end
    checkVal("R6 start during expansion ignored", 128'(seen), 128'd0);
    curKey = k2;
    runBlock(1'b1, pt, res, lat);
    checkVal("R3 decrypt under new key", res, model(curKey, pt, 1'b1));

    // R7: keyLoad and start together while idle
    k3 = {$urandom(), $urandom(), $urandom(), $urandom()};
    keyLoad = 1'b1; keyIn = k3; start = 1'b1; mode = 1'b0; dataIn = pt; tick();
    keyLoad = 1'b0; start = 1'b0;
    n = 0; seen = 0;
    while (busy && n < 40) begin n++; if (done) seen++; tick(); end
    for (int i = 0; i < 12; i++) begin tick(); if (done) seen++; end
    checkVal("R7 joint strobe expansion length", 128'(n), 128'd10);
    checkVal("R7 joint strobe start dropped", 128'(seen), 128'd0);
    curKey = k3;
    runBlock(1'b0, pt, res, lat);
    checkVal("R7 new key in effect", res, model(curKey, pt, 1'b0));

    // R7: keyLoad while a block runs
    start = 1'b1; mode = 1'b0; dataIn = ~pt; tick(); start = 1'b0;
    keyLoad = 1'b1; keyIn = k2; tick(); keyLoad = 1'b0;
    waitDone(res, lat);
    checkVal("R7 busy keyLoad ignored result", res, model(curKey, ~pt, 1'b0));
    runBlock(1'b1, res, res2, lat);
    checkVal("R7 old key kept after busy keyLoad", res2, ~pt);

    // R8: back-to-back start in the done cycle
    pt = {$urandom(), $urandom(), $urandom(), $urandom()};
    start = 1'b1; mode = 1'b0; dataIn = pt; tick(); start = 1'b0;
    waitDone(res, lat);
    checkVal("R8 first block result", res, model(curKey, pt, 1'b0));
    start = 1'b1; mode = 1'b1; dataIn = res; tick(); start = 1'b0;
    waitDone(res2, lat);
    checkVal("R8 second block result", res2, pt);
    checkVal("R8 second block latency", 128'(lat), 128'd11);

    // R2 / R3: random keys and blocks, round trip
    for (int it = 0; it < 24; it++) begin
      if (it % 6 == 0) begin
        curKey = {$urandom(), $urandom(), $urandom(), $urandom()};
        loadKey(curKey, n);
      end
      pt = {$urandom(), $urandom(), $urandom(), $urandom()};
      if (it == 1) pt = '0;
      if (it == 2) pt = '1;
      runBlock(1'b0, pt, ct, lat);
      checkVal("R2 random encrypt", ct, model(curKey, pt, 1'b0));
      runBlock(1'b1, ct, res, lat);
      checkVal("R3 random round trip", res, pt);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule